// File: doc/BRIEF.md
# NAND Command Descriptor Sequencer

This block is the command front end of a NAND flash controller. Software first sets a run-enable input. It then loads a three-word descriptor by writing three times to one command port. The block turns that descriptor into an ordered series of bus cycles for a separate timing generator. The series is a first command byte, a programmed number of address bytes, an optional second command byte and a wait on the flash ready/busy line. It ends with a data-phase request or a completion event. A three-bit type field in the first word picks one of several fixed flows. Program and erase may finish with an automatic status read.

Each bus cycle is requested with `bus_req`, `bus_op` and `bus_byte`. The request is held until the timing generator returns `bus_ack` for one cycle. Data phases are announced with `rd_data_req` or `wr_data_req` and a byte count, and they end when `data_done` pulses. Completion is reported as a one-cycle `cmd_done` or `bad_block` pulse on the chip-select lane that the descriptor chose. The flash chip enable for that lane is held low for the whole operation.

Top module: `nand_cmd_seq`

## Requirements
- R1: While `run_en` is low, `desc_req` is low and writes on `desc_wr` are discarded: no bus cycle starts and no later descriptor is shifted by them.
- R2: With `run_en` high and no operation active, `desc_req` is high until three descriptor writes have been taken, in the order word0, word1, word2. The third write starts the operation. `desc_req` stays low while it runs and rises again once it completes, provided `run_en` is still high.
- R3: The first bus cycle is a command cycle (`bus_op`=0) carrying word0[7:0]. It is followed by N address cycles (`bus_op`=1), where N=word0[18:16]. Address bytes are taken least significant byte first from word1 and then from word2. Every request keeps its op and byte steady until `bus_ack`.
- R4: A second command cycle carrying word0[15:8] is issued only when word0[19] is set.
- R5: Type word0[23:21]=0 (read) waits for `nand_rb` high after the command bytes and then asserts `rd_data_req`. The `data_len` value is 2112 for a large page or 528 for a small page with ECC off, and 2088 or 520 with ECC on.
- R6: Type 1 (program) asserts `wr_data_req` after the address cycles, with the same lengths as R5. The second command byte follows `data_done`. After `nand_rb` is seen high, the block pulses `cmd_done` on the lane selected by word0[24].
- R7: For type 1 or type 2 (erase) with word0[25] set, the block issues a command cycle of 0x70 after ready, then a read cycle (`bus_op`=2). If bit 0 of the returned `bus_rbyte` is 1, `bad_block` pulses on the lane instead of `cmd_done`. With word0[25] clear, no status cycles are issued and `cmd_done` pulses.
- R8: Type 3 (read ID) asserts `rd_data_req` straight after its address cycles, with no ready wait. Its length is 4 for a large page and 2 for a small page. Type 4 (read status) asserts `rd_data_req` with length 1. Type 5 (reset) waits for ready and then pulses `cmd_done`. Every flow except an erroring auto-status one ends with `cmd_done`.
- R9: `ce_n[word0[24]]` is low from the start to the end of an operation, and at most one lane is low. Both lanes are high when the block is idle.
- R10: If `run_en` falls during an operation, any pending bus cycle is allowed to reach `bus_ack` and then the block goes idle. No further cycle, data request or completion pulse follows, and both chip enables go high.
- R11: Descriptor writes made while an operation is active are discarded and do not alter the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable from the control register |
| large_page | input | 1 | 1 = large page geometry, 0 = small page |
| ecc_en | input | 1 | ECC enabled; shortens data length |
| desc_wr | input | 1 | Descriptor write strobe |
| desc_data | input | 32 | Descriptor word being written |
| desc_req | output | 1 | Ready to take a descriptor word |
| bus_req | output | 1 | Bus cycle request to timing generator |
| bus_op | output | 2 | 0 command, 1 address, 2 read byte |
| bus_byte | output | 8 | Byte for a command or address cycle |
| bus_ack | input | 1 | Bus cycle finished |
| bus_rbyte | input | 8 | Byte returned by a read cycle |
| nand_rb | input | 1 | Flash ready (1) / busy (0) |
| rd_data_req | output | 1 | Read data phase request |
| wr_data_req | output | 1 | Write data phase request |
| data_len | output | 12 | Byte count of the data phase |
| data_done | input | 1 | Data phase finished |
| ce_n | output | 2 | Active-low chip enables |
| cmd_done | output | 2 | Completion pulse per chip select |
| bad_block | output | 2 | Failure pulse per chip select |

## Verification
The bench logs every bus cycle, data request and completion pulse in order and compares the whole trace with the sequence the requirements predict. A wrong address order, a missed or spurious second command byte, or a wrong data length therefore shows up as a trace mismatch. Descriptor writes made with run clear, or during a busy wait, would start or corrupt an operation in a faulty design, and that would appear as stray trace entries or a wrong chip-enable lane. Run is dropped once while a command cycle is still pending and once during a ready wait. A design that stopped without finishing the bus cycle, or that kept going, would show a missing acknowledge entry or trailing data and completion entries. Auto status with a failing byte must produce a bad-block pulse in place of command-done, and the same failing byte without auto status must be ignored.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  localparam logic [2:0] TY_READ  = 3'd0;
  localparam logic [2:0] TY_PROG  = 3'd1;
  localparam logic [2:0] TY_ERASE = 3'd2;
  localparam logic [2:0] TY_RDID  = 3'd3;
  localparam logic [2:0] TY_RDST  = 3'd4;
  localparam logic [2:0] TY_RESET = 3'd5;

  localparam logic [1:0] OP_CMD  = 2'd0;
  localparam logic [1:0] OP_ADDR = 2'd1;
  localparam logic [1:0] OP_RDB  = 2'd2;

  // word0 field layout (bit positions decoded by hardware)
  typedef struct packed {
    logic [5:0] rsvd;     // 31:26
    logic       auto_rs;  // 25
    logic       cs;       // 24
    logic [2:0] ctype;    // 23:21
    logic       spare;    // 20
    logic       dbc;      // 19
    logic [2:0] naddr;    // 18:16
    logic [7:0] cmd2;     // 15:8
    logic [7:0] cmd1;     // 7:0
  } desc_w0_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_DWR, S_CMD2,
    S_WAIT, S_DRD, S_STC, S_STR, S_FIN
  } seq_state_e;

endpackage

// File: rtl/nseq_desc_loader.sv
module nseq_desc_loader #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           run_en,
  input  logic                           busy,
  input  logic                           op_end,
  input  logic                           wr_en,
  input  logic [WORD_W-1:0]              wr_data,
  output logic [NWORDS-1:0][WORD_W-1:0]  words,
  output logic                           wr_req,
  output logic                           start
);
  localparam int CW = $clog2(NWORDS + 1);
  localparam logic [CW-1:0] FULL = CW'(NWORDS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept;

  assign accept = wr_en && run_en && !busy && (cnt_q != FULL);
  assign start  = accept && (cnt_q == FULL - CW'(1));
  assign wr_req = run_en && !busy && (cnt_q != FULL);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_en || op_end) cnt_d = '0;
    else if (accept)       cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words <= '0;
    end else if (accept) begin
      for (int i = 0; i < NWORDS; i++) begin
        if (cnt_q == CW'(i)) words[i] <= wr_data;
      end
    end
  end

  a_r1_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt_q == '0));
  a_r11_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(words));

endmodule

// File: rtl/nseq_addr_mux.sv
module nseq_addr_mux #(
  parameter int NB = 8
) (
  input  logic [NB*8-1:0]         addr_bits,
  input  logic [$clog2(NB)-1:0]   idx,
  output logic [7:0]              abyte
);
  logic [7:0] lane [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = addr_bits[g*8 +: 8];
  end

  assign abyte = lane[idx];
endmodule

// File: rtl/nseq_len_calc.sv
module nseq_len_calc
  import nseq_pkg::*;
#(
  parameter int LP_MAIN  = 2048,
  parameter int LP_SPARE = 64,
  parameter int SP_MAIN  = 512,
  parameter int SP_SPARE = 16,
  parameter int LP_ECC   = 24,
  parameter int SP_ECC   = 8,
  parameter int LP_ID    = 4,
  parameter int SP_ID    = 2,
  parameter int LEN_W    = 12
) (
  input  logic             large_page,
  input  logic             ecc_en,
  input  logic [2:0]       ctype,
  output logic [LEN_W-1:0] len
);
  localparam int LP_FULL = LP_MAIN + LP_SPARE;
  localparam int SP_FULL = SP_MAIN + SP_SPARE;
  localparam logic [LEN_W-1:0] L_LP_RAW = LEN_W'(LP_FULL);
  localparam logic [LEN_W-1:0] L_LP_ECC = LEN_W'(LP_FULL - LP_ECC);
  localparam logic [LEN_W-1:0] L_SP_RAW = LEN_W'(SP_FULL);
  localparam logic [LEN_W-1:0] L_SP_ECC = LEN_W'(SP_FULL - SP_ECC);

  always_comb begin
    len = '0;
    case (ctype)
      TY_READ, TY_PROG: begin
        if (large_page) len = ecc_en ? L_LP_ECC : L_LP_RAW;
        else            len = ecc_en ? L_SP_ECC : L_SP_RAW;
      end
      TY_RDID: len = large_page ? LEN_W'(LP_ID) : LEN_W'(SP_ID);
      TY_RDST: len = LEN_W'(1);
      default: len = '0;
    endcase
  end
endmodule

// File: rtl/nseq_flow.sv
module nseq_flow
  import nseq_pkg::*;
#(
  parameter int          NCS       = 2,
  parameter int          AIDX_W    = 3,
  parameter logic [7:0]  STAT_CMD  = 8'h70,
  parameter int          FAIL_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              start,
  input  desc_w0_t          w0,
  input  logic [7:0]        abyte,
  output logic [AIDX_W-1:0] aidx,
  output logic              busy,
  output logic              op_end,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [7:0]        bus_byte,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rbyte,
  input  logic              nand_rb,
  output logic              rd_data_req,
  output logic              wr_data_req,
  input  logic              data_done,
  output logic [NCS-1:0]    ce_n,
  output logic [NCS-1:0]    cmd_done,
  output logic [NCS-1:0]    bad_block
);
  seq_state_e        st_q, st_d;
  logic [AIDX_W-1:0] aidx_q, aidx_d;
  logic              fail_q, fail_d;
  logic              aidx_en, fail_en;

  function automatic seq_state_e after_cmd2(input logic [2:0] ty);
    return (ty == TY_RDID || ty == TY_RDST) ? S_DRD : S_WAIT;
  endfunction

  function automatic seq_state_e after_addr(input logic [2:0] ty, input logic dbc);
    if (ty == TY_PROG) return S_DWR;
    if (dbc)           return S_CMD2;
    return after_cmd2(ty);
  endfunction

  always_comb begin
    case (st_q)
      S_CMD1, S_ADDR, S_CMD2, S_STC, S_STR: bus_req = 1'b1;
      default:                              bus_req = 1'b0;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    aidx_d = aidx_q;
    fail_d = fail_q;
    case (st_q)
      S_IDLE: if (start) begin
        st_d   = S_CMD1;
        aidx_d = '0;
        fail_d = 1'b0;
      end
      S_CMD1: if (bus_ack)
        st_d = (w0.naddr != 3'd0) ? S_ADDR : after_addr(w0.ctype, w0.dbc);
      S_ADDR: if (bus_ack) begin
        if (aidx_q == AIDX_W'(w0.naddr - 3'd1)) begin
          st_d   = after_addr(w0.ctype, w0.dbc);
          aidx_d = '0;
        end else begin
          aidx_d = aidx_q + AIDX_W'(1);
        end
      end
      S_DWR:  if (data_done) st_d = w0.dbc ? S_CMD2 : after_cmd2(w0.ctype);
      S_CMD2: if (bus_ack)   st_d = after_cmd2(w0.ctype);
      S_WAIT: if (nand_rb) begin
        if (w0.ctype == TY_READ)
          st_d = S_DRD;
        else if ((w0.ctype == TY_PROG || w0.ctype == TY_ERASE) && w0.auto_rs)
          st_d = S_STC;
        else
          st_d = S_FIN;
      end
      S_DRD:  if (data_done) st_d = S_FIN;
      S_STC:  if (bus_ack)   st_d = S_STR;
      S_STR:  if (bus_ack) begin
        fail_d = bus_rbyte[FAIL_BIT];
        st_d   = S_FIN;
      end
      S_FIN:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (!run_en && st_q != S_IDLE) begin
      aidx_d = '0;
      st_d   = (!bus_req || bus_ack) ? S_IDLE : st_q;
    end
  end

  assign aidx_en = (aidx_d != aidx_q);
  assign fail_en = (fail_d != fail_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       aidx_q <= '0;
    else if (aidx_en) aidx_q <= aidx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fail_q <= 1'b0;
    else if (fail_en) fail_q <= fail_d;
  end

  assign aidx   = aidx_q;
  assign busy   = (st_q != S_IDLE);
  assign op_end = (st_q == S_FIN);

  always_comb begin
    bus_op   = OP_CMD;
    bus_byte = 8'h00;
    case (st_q)
      S_CMD1: bus_byte = w0.cmd1;
      S_ADDR: begin bus_op = OP_ADDR; bus_byte = abyte; end
      S_CMD2: bus_byte = w0.cmd2;
      S_STC:  bus_byte = STAT_CMD;
      S_STR:  bus_op = OP_RDB;
      default: ;
    endcase
  end

  assign rd_data_req = (st_q == S_DRD);
  assign wr_data_req = (st_q == S_DWR);

  for (genvar g = 0; g < NCS; g++) begin : g_lane
    assign ce_n[g]      = !(busy && (w0.cs == 1'(g)));
    assign cmd_done[g]  = op_end && (w0.cs == 1'(g)) && !fail_q;
    assign bad_block[g] = op_end && (w0.cs == 1'(g)) && fail_q;
  end

  a_r3_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_byte) && $stable(bus_op)));
  a_r9_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 1);
  a_r7_done_or_bad: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_done, bad_block}));
  a_r6_data_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_req && data_done) |=> !(|cmd_done));

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nseq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NWORDS = 3,
  parameter int NCS    = 2,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              large_page,
  input  logic              ecc_en,
  input  logic              desc_wr,
  input  logic [31:0]       desc_data,
  output logic              desc_req,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [7:0]        bus_byte,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rbyte,
  input  logic              nand_rb,
  output logic              rd_data_req,
  output logic              wr_data_req,
  output logic [11:0]       data_len,
  input  logic              data_done,
  output logic [1:0]        ce_n,
  output logic [1:0]        cmd_done,
  output logic [1:0]        bad_block
);
  localparam int ABYTES = (NWORDS - 1) * (WORD_W / 8);
  localparam int AIDX_W = $clog2(ABYTES);

  logic rst_meta, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [NWORDS-1:0][WORD_W-1:0] words;
  logic                          busy, op_end, start;
  logic [AIDX_W-1:0]             aidx;
  logic [7:0]                    abyte;
  desc_w0_t                      w0;

  assign w0 = desc_w0_t'(words[0]);

  nseq_desc_loader #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_load (
    .clk(clk), .rst_n(rst_s), .run_en(run_en), .busy(busy), .op_end(op_end),
    .wr_en(desc_wr), .wr_data(desc_data), .words(words),
    .wr_req(desc_req), .start(start)
  );

  nseq_addr_mux #(.NB(ABYTES)) u_amux (
    .addr_bits({words[2], words[1]}), .idx(aidx), .abyte(abyte)
  );

  nseq_len_calc #(.LEN_W(LEN_W)) u_len (
    .large_page(large_page), .ecc_en(ecc_en), .ctype(w0.ctype), .len(data_len)
  );

  nseq_flow #(.NCS(NCS), .AIDX_W(AIDX_W)) u_flow (
    .clk(clk), .rst_n(rst_s), .run_en(run_en), .start(start), .w0(w0),
    .abyte(abyte), .aidx(aidx), .busy(busy), .op_end(op_end),
    .bus_req(bus_req), .bus_op(bus_op), .bus_byte(bus_byte),
    .bus_ack(bus_ack), .bus_rbyte(bus_rbyte), .nand_rb(nand_rb),
    .rd_data_req(rd_data_req), .wr_data_req(wr_data_req),
    .data_done(data_done), .ce_n(ce_n), .cmd_done(cmd_done),
    .bad_block(bad_block)
  );

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_s)
    start |=> busy);
  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_s)
    (!run_en && !bus_req) |=> (ce_n == '1));

endmodule

// File: tb/sim_nand_cmd_seq.sv
module sim_nand_cmd_seq;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, run_en, large_page, ecc_en, desc_wr;
  logic [31:0] desc_data;
  logic        desc_req, bus_req, bus_ack, nand_rb;
  logic [1:0]  bus_op, ce_n, cmd_done, bad_block;
  logic [7:0]  bus_byte, bus_rbyte;
  logic        rd_data_req, wr_data_req, data_done;
  logic [11:0] data_len;

  nand_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .large_page(large_page),
    .ecc_en(ecc_en), .desc_wr(desc_wr), .desc_data(desc_data),
    .desc_req(desc_req), .bus_req(bus_req), .bus_op(bus_op),
    .bus_byte(bus_byte), .bus_ack(bus_ack), .bus_rbyte(bus_rbyte),
    .nand_rb(nand_rb), .rd_data_req(rd_data_req), .wr_data_req(wr_data_req),
    .data_len(data_len), .data_done(data_done), .ce_n(ce_n),
    .cmd_done(cmd_done), .bad_block(bad_block)
  );

  int total = 0;
  int bad = 0;

  // trace codes: 0 cmd, 1 addr, 2 read byte, 3 read data, 4 write data, 5 done, 6 bad block
  int         lg_code [64];
  int         lg_val  [64];
  logic [1:0] lg_ce   [64];
  int         lg_n = 0;
  int         ex_code [64];
  int         ex_val  [64];
  int         ex_n = 0;
  logic       resp_on = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic lg_add(input int c, input int v);
    if (lg_n < 64) begin
      lg_code[lg_n] = c; lg_val[lg_n] = v; lg_ce[lg_n] = ce_n;
    end
    lg_n++;
  endtask

  task automatic ex(input int c, input int v);
    ex_code[ex_n] = c; ex_val[ex_n] = v; ex_n++;
  endtask

  task automatic cmp_log(input string tag);
    chk({tag, " trace length"}, lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      chk($sformatf("%s entry %0d code", tag, i), lg_code[i], ex_code[i]);
      chk($sformatf("%s entry %0d value", tag, i), lg_val[i], ex_val[i]);
    end
  endtask

  // timing generator and data engine model
  initial begin
    int bcnt, dcnt;
    bcnt = 0; dcnt = 0;
    forever begin
      @(negedge clk);
      if (resp_on) begin
        if (bus_ack) begin
          bus_ack = 1'b0; bcnt = 0;
        end else if (bus_req) begin
          bcnt++;
          if (bcnt >= 2) begin
            bus_ack = 1'b1;
            lg_add(int'(bus_op), int'(bus_byte));
          end
        end
        if (data_done) begin
          data_done = 1'b0; dcnt = 0;
        end else if (rd_data_req || wr_data_req) begin
          dcnt++;
          if (dcnt >= 3) begin
            data_done = 1'b1;
            lg_add(rd_data_req ? 3 : 4, int'(data_len));
          end
        end
        if (|cmd_done)  lg_add(5, cmd_done[1]  ? 1 : 0);
        if (|bad_block) lg_add(6, bad_block[1] ? 1 : 0);
      end
    end
  end

  function automatic logic [31:0] mk_w0(input logic [7:0] c1, input logic [7:0] c2,
      input int na, input logic dbc, input int ty, input logic cs, input logic ars);
    return {6'd0, ars, cs, 3'(ty), 1'b0, dbc, 3'(na), c2, c1};
  endfunction

  task automatic put3(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk); desc_wr = 1'b1; desc_data = a;
    @(negedge clk); desc_data = b;
    @(negedge clk); desc_data = c;
    @(negedge clk); desc_wr = 1'b0;
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 400 && lg_n < n; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic begin_test();
    lg_n = 0; ex_n = 0;
    @(negedge clk); run_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic end_test();
    @(negedge clk); run_en = 1'b0;
    repeat (4) @(negedge clk);
    nand_rb = 1'b1;
  endtask

  task automatic t_reset_state();
    chk("R1 desc_req at reset", int'(desc_req), 0);
    chk("R9 ce_n at reset", int'(ce_n), 3);
    chk("R3 bus_req at reset", int'(bus_req), 0);
    chk("R6 cmd_done at reset", int'(cmd_done), 0);
    chk("R7 bad_block at reset", int'(bad_block), 0);
  endtask

  task automatic t_r1_run_off();
    lg_n = 0;
    put3(mk_w0(8'h00, 8'h30, 5, 1, 0, 0, 0), 32'h44332211, 32'h55);
    repeat (20) @(negedge clk);
    chk("R1 no activity with run clear", lg_n, 0);
    chk("R1 desc_req low with run clear", int'(desc_req), 0);
    chk("R1 ce_n idle", int'(ce_n), 3);
    @(negedge clk); run_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 desc_req after run set", int'(desc_req), 1);
    repeat (10) @(negedge clk);
    chk("R1 stale writes not counted", lg_n, 0);
    end_test();
  endtask

  task automatic t_read_large();
    begin_test();
    large_page = 1'b1; ecc_en = 1'b0;
    put3(mk_w0(8'h00, 8'h30, 5, 1, 0, 0, 0), 32'h44332211, 32'h00000055);
    chk("R2 desc_req low while busy", int'(desc_req), 0);
    wait_log(9);
    ex(0, 8'h00); ex(1, 8'h11); ex(1, 8'h22); ex(1, 8'h33); ex(1, 8'h44);
    ex(1, 8'h55); ex(0, 8'h30); ex(3, 2112); ex(5, 0);
    cmp_log("R3 R4 R5 read large");
    chk("R9 ce lane 0 during read", int'(lg_ce[0]), 2);
    chk("R2 desc_req back after done", int'(desc_req), 1);
    chk("R9 ce idle after read", int'(ce_n), 3);
    end_test();
  endtask

  task automatic t_read_small_ecc();
    begin_test();
    large_page = 1'b0; ecc_en = 1'b1;
    put3(mk_w0(8'h00, 8'h30, 4, 0, 0, 1, 0), 32'hDDCCBBAA, 32'h0);
    wait_log(7);
    ex(0, 8'h00); ex(1, 8'hAA); ex(1, 8'hBB); ex(1, 8'hCC); ex(1, 8'hDD);
    ex(3, 520); ex(5, 1);
    cmp_log("R4 R5 read small ecc no second byte");
    chk("R9 ce lane 1 during read", int'(lg_ce[0]), 1);
    end_test();
  endtask

  task automatic t_program_ok();
    begin_test();
    large_page = 1'b1; ecc_en = 1'b1; bus_rbyte = 8'hC0;
    put3(mk_w0(8'h80, 8'h10, 4, 1, 1, 1, 1), 32'h04030201, 32'h0);
    wait_log(11);
    ex(0, 8'h80); ex(1, 8'h01); ex(1, 8'h02); ex(1, 8'h03); ex(1, 8'h04);
    ex(4, 2088); ex(0, 8'h10); ex(0, 8'h70); ex(2, 0); ex(5, 1);
    cmp_log("R6 R7 program auto status pass");
    end_test();
  endtask

  task automatic t_erase(input logic ars);
    begin_test();
    bus_rbyte = 8'hE1;
    put3(mk_w0(8'h60, 8'hD0, 3, 1, 2, 0, ars), 32'h00654321, 32'h0);
    wait_log(ars ? 8 : 6);
    ex(0, 8'h60); ex(1, 8'h21); ex(1, 8'h43); ex(1, 8'h65); ex(0, 8'hD0);
    if (ars) begin
      ex(0, 8'h70); ex(2, 0); ex(6, 0);
      cmp_log("R7 erase auto status fail");
    end else begin
      ex(5, 0);
      cmp_log("R7 erase without auto status");
    end
    end_test();
  endtask

  task automatic t_read_id(input logic lp);
    begin_test();
    large_page = lp; nand_rb = 1'b0;
    put3(mk_w0(8'h90, 8'h00, 1, 0, 3, 0, 0), 32'h0, 32'h0);
    wait_log(4);
    ex(0, 8'h90); ex(1, 8'h00); ex(3, lp ? 4 : 2); ex(5, 0);
    cmp_log("R8 read id without ready wait");
    end_test();
  endtask

  task automatic t_read_status();
    begin_test();
    put3(mk_w0(8'h70, 8'h00, 0, 0, 4, 0, 0), 32'h0, 32'h0);
    wait_log(3);
    ex(0, 8'h70); ex(3, 1); ex(5, 0);
    cmp_log("R8 read status");
    end_test();
  endtask

  task automatic t_reset_busy_write();
    begin_test();
    nand_rb = 1'b0;
    put3(mk_w0(8'hFF, 8'h00, 0, 0, 5, 0, 0), 32'h0, 32'h0);
    repeat (20) @(negedge clk);
    chk("R8 reset holds for ready", lg_n, 1);
    chk("R2 desc_req low during wait", int'(desc_req), 0);
    @(negedge clk); desc_wr = 1'b1; desc_data = mk_w0(8'hFF, 8'h00, 0, 0, 5, 1, 0);
    @(negedge clk); desc_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 lane unchanged by busy write", int'(ce_n), 2);
    nand_rb = 1'b1;
    wait_log(2);
    ex(0, 8'hFF); ex(5, 0);
    cmp_log("R11 R8 reset flow");
    chk("R2 desc_req back after reset", int'(desc_req), 1);
    end_test();
  endtask

  task automatic t_abort_in_cycle();
    begin_test();
    put3(mk_w0(8'h00, 8'h30, 5, 1, 0, 0, 0), 32'h44332211, 32'h55);
    run_en = 1'b0;
    repeat (30) @(negedge clk);
    ex(0, 8'h00);
    cmp_log("R10 stop during command cycle");
    chk("R10 ce idle after stop", int'(ce_n), 3);
    chk("R10 no bus request after stop", int'(bus_req), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_abort_in_wait();
    begin_test();
    nand_rb = 1'b0; large_page = 1'b1; ecc_en = 1'b0;
    put3(mk_w0(8'h00, 8'h30, 2, 1, 0, 1, 0), 32'h0000BEEF, 32'h0);
    wait_log(4);
    chk("R9 ce lane 1 during wait", int'(ce_n), 1);
    @(negedge clk); run_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 ce idle after stop in wait", int'(ce_n), 3);
    nand_rb = 1'b1;
    repeat (30) @(negedge clk);
    ex(0, 8'h00); ex(1, 8'hEF); ex(1, 8'hBE); ex(0, 8'h30);
    cmp_log("R10 stop during ready wait");
    chk("R10 no data request after stop", int'(rd_data_req), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; large_page = 1'b1; ecc_en = 1'b0;
    desc_wr = 1'b0; desc_data = '0; bus_ack = 1'b0; bus_rbyte = 8'h00;
    nand_rb = 1'b1; data_done = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    resp_on = 1'b1;
    t_reset_state();
    t_r1_run_off();
    t_read_large();
    t_read_small_ecc();
    t_program_ok();
    t_erase(1'b1);
    t_erase(1'b0);
    t_read_id(1'b1);
    t_read_id(1'b0);
    t_read_status();
    t_reset_busy_write();
    t_abort_in_cycle();
    t_abort_in_wait();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule